// File: doc/BRIEF.md
# Fork Path Successor Table

This block keeps the program order of concurrent execution paths that a core spawns each time a call instruction forks. Every live path owns one slot in a small table. The slot holds a successor pointer, and the pointer gives the path that comes next in sequential order. A fork from path `p` takes the lowest free path ID `q`. The new path `q` inherits the successor that `p` held, and `p` then points at `q`. Repeated and nested forks therefore still produce a single chain. Following that chain from the root path rebuilds sequential trace order.

Fork requests arrive on two request ports, one driven from the write-back stage and one from the commit stage. A mode input picks which port is honoured. While the mode input is high (speculative forking), only the write-back port is used. While it is low (non-speculative forking), only the commit port is used. The request follows valid/ready rules. A request completes in the cycle where its valid and `fork_ready` are both high. When `fork_ready` is low, the request is refused and `fork_stall` is raised, and the requester must present it again later. `fork_ready` depends only on table occupancy and on whether a cancel or release arrives in the same cycle.

In the fork cycle the block pulses `dup_strobe`, together with the source and destination IDs, so that the non-volatile register state (stack pointer included) can be copied into the new path. One cycle later it pulses `fetch_go` with the new ID, and the new path may begin fetching. A finished path is released and unlinked from the chain. A cancelled path is freed together with every path after it in the chain. A combinational query port returns the liveness and successor of any ID.

Top module: `fork_path_seq`

## Requirements
- R1: After reset only path 0 is live. Its successor is the null value, encoded as all ones on an ID-wide field (15 with the default 8 paths). Every other ID reads as not live with a null successor.
- R2: A completed fork allocates the lowest-numbered ID that is not live. That ID is never the same as the forking path.
- R3: After a fork by `p` that creates `q`, the successor of `q` equals the successor that `p` held before the fork, and the successor of `p` equals `q`.
- R4: The mode input selects the request port. When `spec_mode` is 1 only the write-back port is honoured, and when it is 0 only the commit port is. A request on the other port has no effect.
- R5: When every ID is live, `fork_ready` is 0. A request on the honoured port then raises `fork_stall`, produces no `dup_strobe`, and leaves the table unchanged.
- R6: A completed fork raises `dup_strobe` in the request cycle, with `dup_src` = `p` and `dup_dst` = `q`.
- R7: `fetch_go` is high, with `fetch_id` = `q`, in exactly the one cycle that follows a completed fork, and at no other time.
- R8: Releasing a live path makes it not live. Any path that pointed to it takes over its successor.
- R9: Cancelling a live path frees that path and every path reachable through its successor chain. The path that pointed to it gets a null successor. No other path changes.
- R10: At most one table operation happens per cycle, with priority cancel over release over fork. A fork presented in the same cycle as a cancel or release sees `fork_ready` low and is refused.
- R11: A fork whose parent is not live, and a release or cancel of an ID that is not live, have no effect.
- R12: The query port returns, in the same cycle, the liveness of `qry_id` and its successor (null when the ID is not live).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spec_mode | input | 1 | 1: fork at write-back, 0: fork at commit |
| wb_fork_valid | input | 1 | Call reached write-back and requests a fork |
| wb_fork_path | input | ID_W | Forking path on the write-back port |
| cmt_fork_valid | input | 1 | Call reached commit and requests a fork |
| cmt_fork_path | input | ID_W | Forking path on the commit port |
| fork_ready | output | 1 | A fork can be accepted in this cycle |
| fork_stall | output | 1 | Honoured request refused in this cycle |
| dup_strobe | output | 1 | Copy non-volatile state from dup_src to dup_dst |
| dup_src | output | ID_W | Forking path |
| dup_dst | output | ID_W | Newly allocated path |
| fetch_go | output | 1 | New path may start fetching |
| fetch_id | output | ID_W | ID of the path that starts fetching |
| rel_valid | input | 1 | Release a finished path |
| rel_id | input | ID_W | Path to release |
| cancel_valid | input | 1 | Cancel a path and its successors |
| cancel_id | input | ID_W | First path to cancel |
| qry_id | input | ID_W | Path being queried |
| qry_live | output | 1 | Queried path is live |
| qry_succ | output | ID_W | Successor of the queried path |

## Verification
A wrong successor pointer stays hidden until someone queries it. It then shows up on `qry_succ` in the same cycle, and it also corrupts the next fork that inherits from that entry. For that reason the bench reads the whole table through the query port after every operation. A stale liveness bit shows up one cycle later: as a wrong `dup_dst` on the next fork, or as a wrong `fork_ready`/`fork_stall` once the table is full. A bad cancel walk appears after one clock as paths that should have died but still answer live.

// File: rtl/fork_path_pkg.sv
package fork_path_pkg;
  typedef enum logic [1:0] {
    OP_NONE,
    OP_CANCEL,
    OP_RELEASE,
    OP_FORK
  } fps_op_e;
endpackage

// File: rtl/fork_path_alloc.sv
// Lowest-index free slot finder.
module fork_path_alloc #(
  parameter int NUM_PATHS = 8,
  localparam int SEL_W = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1
) (
  input  logic [NUM_PATHS-1:0] free_i,
  output logic                 any_o,
  output logic [SEL_W-1:0]     idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_PATHS - 1; i >= 0; i--) begin
      if (free_i[i]) idx_o = SEL_W'(i);
    end
  end
  assign any_o = |free_i;
endmodule

// File: rtl/fork_path_kill.sv
// Marks the start path and every path reachable through successor links.
module fork_path_kill #(
  parameter int NUM_PATHS = 8,
  localparam int ID_W  = $clog2(NUM_PATHS + 1),
  localparam int SEL_W = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1
) (
  input  logic [NUM_PATHS-1:0][ID_W-1:0] succ_i,
  input  logic                           en_i,
  input  logic [ID_W-1:0]                start_i,
  output logic [NUM_PATHS-1:0]           mask_o
);
  logic [ID_W-1:0] cur;
  always_comb begin
    mask_o = '0;
    cur    = start_i;
    for (int k = 0; k < NUM_PATHS; k++) begin
      if (en_i && (cur < ID_W'(NUM_PATHS))) begin
        mask_o[cur[SEL_W-1:0]] = 1'b1;
        cur = succ_i[cur[SEL_W-1:0]];
      end else begin
        cur = '1;
      end
    end
  end
endmodule

// File: rtl/fork_path_seq.sv
module fork_path_seq
  import fork_path_pkg::*;
#(
  parameter int NUM_PATHS = 8,
  localparam int ID_W  = $clog2(NUM_PATHS + 1),
  localparam int SEL_W = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            spec_mode,
  input  logic            wb_fork_valid,
  input  logic [ID_W-1:0] wb_fork_path,
  input  logic            cmt_fork_valid,
  input  logic [ID_W-1:0] cmt_fork_path,
  output logic            fork_ready,
  output logic            fork_stall,
  output logic            dup_strobe,
  output logic [ID_W-1:0] dup_src,
  output logic [ID_W-1:0] dup_dst,
  output logic            fetch_go,
  output logic [ID_W-1:0] fetch_id,
  input  logic            rel_valid,
  input  logic [ID_W-1:0] rel_id,
  input  logic            cancel_valid,
  input  logic [ID_W-1:0] cancel_id,
  input  logic [ID_W-1:0] qry_id,
  output logic            qry_live,
  output logic [ID_W-1:0] qry_succ
);
  localparam logic [ID_W-1:0] NULL_ID = '1;
  localparam logic [ID_W-1:0] LIMIT   = ID_W'(NUM_PATHS);

  logic [NUM_PATHS-1:0]           live_q;
  logic [NUM_PATHS-1:0][ID_W-1:0] succ_q;
  logic                           fetch_go_q;
  logic [ID_W-1:0]                fetch_id_q;

  // Request port selection by fork mode
  logic            req_valid;
  logic [ID_W-1:0] req_path;
  assign req_valid = spec_mode ? wb_fork_valid : cmt_fork_valid;
  assign req_path  = spec_mode ? wb_fork_path  : cmt_fork_path;

  logic parent_ok, rel_hit, cancel_hit, qry_ok;
  assign parent_ok  = (req_path  < LIMIT) && live_q[req_path[SEL_W-1:0]];
  assign rel_hit    = rel_valid    && (rel_id    < LIMIT) && live_q[rel_id[SEL_W-1:0]];
  assign cancel_hit = cancel_valid && (cancel_id < LIMIT) && live_q[cancel_id[SEL_W-1:0]];
  assign qry_ok     = (qry_id    < LIMIT) && live_q[qry_id[SEL_W-1:0]];

  // Allocation
  logic             free_any;
  logic [SEL_W-1:0] free_idx;
  logic [ID_W-1:0]  new_id;

  fork_path_alloc #(.NUM_PATHS(NUM_PATHS)) u_alloc (
    .free_i (~live_q),
    .any_o  (free_any),
    .idx_o  (free_idx)
  );
  assign new_id = ID_W'(free_idx);

  // Cancel reach
  logic [NUM_PATHS-1:0] kill_mask;
  fork_path_kill #(.NUM_PATHS(NUM_PATHS)) u_kill (
    .succ_i  (succ_q),
    .en_i    (cancel_hit),
    .start_i (cancel_id),
    .mask_o  (kill_mask)
  );

  // Arbitration: cancel, then release, then fork
  logic    fork_go;
  fps_op_e op;
  assign fork_ready = free_any && !cancel_valid && !rel_valid;
  assign fork_stall = req_valid && !fork_ready;
  assign fork_go    = req_valid && fork_ready && parent_ok;

  always_comb begin
    if (cancel_hit)   op = OP_CANCEL;
    else if (rel_hit) op = OP_RELEASE;
    else if (fork_go) op = OP_FORK;
    else              op = OP_NONE;
  end

  assign dup_strobe = fork_go;
  assign dup_src    = req_path;
  assign dup_dst    = new_id;

  // Table update
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q     <= NUM_PATHS'(1);
      succ_q     <= {NUM_PATHS{NULL_ID}};
      fetch_go_q <= 1'b0;
      fetch_id_q <= NULL_ID;
    end else begin
      fetch_go_q <= fork_go;
      if (fork_go) fetch_id_q <= new_id;
      unique case (op)
        OP_CANCEL: begin
          for (int i = 0; i < NUM_PATHS; i++) begin
            if (kill_mask[i]) begin
              live_q[i] <= 1'b0;
              succ_q[i] <= NULL_ID;
            end else if (succ_q[i] == cancel_id) begin
              succ_q[i] <= NULL_ID;
            end
          end
        end
        OP_RELEASE: begin
          for (int i = 0; i < NUM_PATHS; i++) begin
            if (i == int'(rel_id)) begin
              live_q[i] <= 1'b0;
              succ_q[i] <= NULL_ID;
            end else if (succ_q[i] == rel_id) begin
              succ_q[i] <= succ_q[rel_id[SEL_W-1:0]];
            end
          end
        end
        OP_FORK: begin
          live_q[free_idx] <= 1'b1;
          succ_q[free_idx] <= succ_q[req_path[SEL_W-1:0]];
          succ_q[req_path[SEL_W-1:0]] <= new_id;
        end
        default: ;
      endcase
    end
  end

  assign fetch_go = fetch_go_q;
  assign fetch_id = fetch_id_q;
  assign qry_live = qry_ok;
  assign qry_succ = qry_ok ? succ_q[qry_id[SEL_W-1:0]] : NULL_ID;
endmodule

// File: rtl/fork_path_seq_chk.sv
module fork_path_seq_chk #(
  parameter int NUM_PATHS = 8,
  localparam int ID_W  = $clog2(NUM_PATHS + 1),
  localparam int SEL_W = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fork_ready,
  input logic                 fork_stall,
  input logic                 dup_strobe,
  input logic [ID_W-1:0]      dup_src,
  input logic [ID_W-1:0]      dup_dst,
  input logic                 fetch_go,
  input logic [ID_W-1:0]      fetch_id,
  input logic                 cancel_valid,
  input logic [ID_W-1:0]      cancel_id,
  input logic [NUM_PATHS-1:0] live_q
);
  AST_STALL_NO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    fork_stall |-> (!dup_strobe && !fork_ready)); // R5
  AST_FETCH_AFTER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    dup_strobe |=> (fetch_go && fetch_id == $past(dup_dst))); // R7
  AST_FETCH_NEEDS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |-> $past(dup_strobe)); // R7
  AST_NEW_ID_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    dup_strobe |-> (dup_src != dup_dst && !live_q[dup_dst[SEL_W-1:0]])); // R2
  AST_FORK_GOES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    dup_strobe |=> live_q[$past(dup_dst[SEL_W-1:0])]); // R3
  AST_CANCEL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel_valid && cancel_id < ID_W'(NUM_PATHS)) |=> !live_q[$past(cancel_id[SEL_W-1:0])]); // R9
endmodule

bind fork_path_seq fork_path_seq_chk #(.NUM_PATHS(NUM_PATHS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fork_ready   (fork_ready),
  .fork_stall   (fork_stall),
  .dup_strobe   (dup_strobe),
  .dup_src      (dup_src),
  .dup_dst      (dup_dst),
  .fetch_go     (fetch_go),
  .fetch_id     (fetch_id),
  .cancel_valid (cancel_valid),
  .cancel_id    (cancel_id),
  .live_q       (live_q)
);

// File: tb/fork_path_seq_bench.sv
`timescale 1ns/1ps
module fork_path_seq_bench;
  localparam int N   = 8;
  localparam int IDW = 4;
  localparam logic [IDW-1:0] NUL = 4'hF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spec_mode = 1'b1;
  logic wb_fork_valid = 1'b0, cmt_fork_valid = 1'b0;
  logic [IDW-1:0] wb_fork_path = '0, cmt_fork_path = '0;
  logic rel_valid = 1'b0, cancel_valid = 1'b0;
  logic [IDW-1:0] rel_id = '0, cancel_id = '0, qry_id = '0;
  logic fork_ready, fork_stall, dup_strobe, fetch_go, qry_live;
  logic [IDW-1:0] dup_src, dup_dst, fetch_id, qry_succ;

  always #2 clk = ~clk;

  fork_path_seq #(.NUM_PATHS(N)) u_fork_path_seq (
    .clk(clk), .rst_n(rst_n), .spec_mode(spec_mode),
    .wb_fork_valid(wb_fork_valid), .wb_fork_path(wb_fork_path),
    .cmt_fork_valid(cmt_fork_valid), .cmt_fork_path(cmt_fork_path),
    .fork_ready(fork_ready), .fork_stall(fork_stall),
    .dup_strobe(dup_strobe), .dup_src(dup_src), .dup_dst(dup_dst),
    .fetch_go(fetch_go), .fetch_id(fetch_id),
    .rel_valid(rel_valid), .rel_id(rel_id),
    .cancel_valid(cancel_valid), .cancel_id(cancel_id),
    .qry_id(qry_id), .qry_live(qry_live), .qry_succ(qry_succ)
  );

  int checks = 0, errors = 0;
  bit m_live [N];
  logic [IDW-1:0] m_succ [N];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < N; i++) if (!m_live[i]) return i;
    return -1;
  endfunction

  // R12: full table read through the query port
  task automatic check_table(input string tag);
    for (int i = 0; i < N; i++) begin
      qry_id = IDW'(i);
      #0.1;
      chk(qry_live == m_live[i], {tag, " R12 live"}, int'(qry_live), int'(m_live[i]));
      chk(qry_succ == m_succ[i], {tag, " R12 succ"}, int'(qry_succ), int'(m_succ[i]));
    end
  endtask

  task automatic do_fork(input bit mode, input bit via_wb, input int parent, input string tag);
    int q; bit honoured, acc, stall;
    @(negedge clk);
    spec_mode = mode;
    if (via_wb) begin wb_fork_valid = 1'b1; wb_fork_path = IDW'(parent); end
    else begin cmt_fork_valid = 1'b1; cmt_fork_path = IDW'(parent); end
    q = lowest_free();
    honoured = (mode == via_wb);
    stall = honoured && (q < 0);
    acc = honoured && (q >= 0) && parent < N && m_live[parent];
    #1;
    chk(fork_stall == stall, {tag, " R5 stall"}, int'(fork_stall), int'(stall));
    chk(dup_strobe == acc, {tag, " R6 strobe"}, int'(dup_strobe), int'(acc));
    if (acc) begin
      chk(dup_dst == IDW'(q), {tag, " R2 new id"}, int'(dup_dst), q);
      chk(dup_src == IDW'(parent), {tag, " R6 src"}, int'(dup_src), parent);
    end
    @(posedge clk); #1;
    wb_fork_valid = 1'b0; cmt_fork_valid = 1'b0;
    chk(fetch_go == acc, {tag, " R7 fetch_go"}, int'(fetch_go), int'(acc));
    if (acc) begin
      chk(fetch_id == IDW'(q), {tag, " R7 fetch_id"}, int'(fetch_id), q);
      m_succ[q] = m_succ[parent];   // R3 inheritance
      m_succ[parent] = IDW'(q);
      m_live[q] = 1'b1;
    end
    check_table(tag);
  endtask

  task automatic model_release(input int r);
    if (r < N && m_live[r]) begin
      for (int i = 0; i < N; i++) if (i != r && m_succ[i] == IDW'(r)) m_succ[i] = m_succ[r];
      m_live[r] = 1'b0; m_succ[r] = NUL;
    end
  endtask

  task automatic model_cancel(input int c);
    bit kill [N];
    int cur;
    if (c < N && m_live[c]) begin
      for (int i = 0; i < N; i++) kill[i] = 1'b0;
      cur = c;
      while (cur < N) begin kill[cur] = 1'b1; cur = int'(m_succ[cur]); end
      for (int i = 0; i < N; i++) begin
        if (kill[i]) begin m_live[i] = 1'b0; m_succ[i] = NUL; end
        else if (m_succ[i] == IDW'(c)) m_succ[i] = NUL;
      end
    end
  endtask

  // kind 0 = release, 1 = cancel; with_fork also presents a write-back fork (R10)
  task automatic do_op(input bit kind, input int id, input bit with_fork, input int parent, input string tag);
    @(negedge clk);
    if (kind) begin cancel_valid = 1'b1; cancel_id = IDW'(id); end
    else begin rel_valid = 1'b1; rel_id = IDW'(id); end
    if (with_fork) begin spec_mode = 1'b1; wb_fork_valid = 1'b1; wb_fork_path = IDW'(parent); end
    #1;
    chk(fork_ready == 1'b0, {tag, " R10 ready"}, int'(fork_ready), 0);
    if (with_fork) begin
      chk(fork_stall == 1'b1, {tag, " R10 stall"}, int'(fork_stall), 1);
      chk(dup_strobe == 1'b0, {tag, " R10 strobe"}, int'(dup_strobe), 0);
    end
    @(posedge clk); #1;
    cancel_valid = 1'b0; rel_valid = 1'b0; wb_fork_valid = 1'b0;
    chk(fetch_go == 1'b0, {tag, " R10 fetch"}, int'(fetch_go), 0);
    if (kind) model_cancel(id); else model_release(id);
    check_table(tag);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_live[i] = (i == 0); m_succ[i] = NUL; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk(fetch_go == 1'b0, "R1 fetch_go idle", int'(fetch_go), 0);
    chk(fork_ready == 1'b1, "R1 ready", int'(fork_ready), 1);
    check_table("R1 reset");

    // nested forks in both modes (R3 inheritance)
    do_fork(1'b1, 1'b1, 0, "R3 spec fork 0");
    do_fork(1'b0, 1'b0, 1, "R3 commit fork 1");
    do_fork(1'b1, 1'b1, 0, "R3 nested fork 0");
    // R4: wrong port for the mode is ignored
    do_fork(1'b1, 1'b0, 0, "R4 commit port in spec mode");
    do_fork(1'b0, 1'b1, 0, "R4 wb port in commit mode");
    // fill the table
    do_fork(1'b1, 1'b1, 3, "R2 fill a");
    do_fork(1'b0, 1'b0, 0, "R2 fill b");
    do_fork(1'b1, 1'b1, 2, "R2 fill c");
    do_fork(1'b0, 1'b0, 1, "R2 fill d");
    // R5: full table
    @(negedge clk); #1;
    chk(fork_ready == 1'b0, "R5 ready when full", int'(fork_ready), 0);
    do_fork(1'b1, 1'b1, 4, "R5 full spec");
    do_fork(1'b0, 1'b0, 0, "R5 full commit");
    // R8 release and R11 ignored operations
    do_op(1'b0, 5, 1'b0, 0, "R8 release 5");
    do_fork(1'b1, 1'b1, 5, "R11 fork from dead");
    do_op(1'b0, 5, 1'b0, 0, "R11 release dead");
    do_fork(1'b1, 1'b1, 2, "R2 reuse freed");
    do_op(1'b0, 0, 1'b0, 0, "R8 release root");
    // R9 cancel a middle path; R10 with a fork alongside
    do_op(1'b1, 3, 1'b1, 1, "R9 cancel 3 with fork");
    do_fork(1'b1, 1'b1, 1, "R2 fork after cancel");
    do_op(1'b0, 2, 1'b1, 1, "R10 release with fork");
    do_op(1'b1, 6, 1'b0, 0, "R11 cancel dead");
    for (int p = 0; p < N; p++) do_fork(1'b0, 1'b0, p, "R3 sweep");
    do_op(1'b1, 1, 1'b0, 0, "R9 cancel sweep");
    for (int p = N - 1; p >= 0; p--) do_fork(1'b1, 1'b1, p, "R3 sweep back");
    for (int p = 0; p < N; p++) do_op(1'b1, p, 1'b0, 0, "R9 cancel all");
    do_fork(1'b1, 1'b1, 0, "R11 fork with none live");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule